// File: doc/BRIEF.md
# Adaptive-Slope Delta Voice Codec

This block is a one-bit delta codec for voice whose slope adapts continuously. In encode mode it compares a signed 12-bit audio word with an internal reconstructed estimate and sends one NRZ bit per bit clock: 1 when the input is at or above the estimate, 0 otherwise. In decode mode it takes that same bit stream and rebuilds the estimate, which it presents as a signed output word. Both modes share one integrator and one step adapter. An encoder and a decoder that see the same bits therefore track each other exactly.

The step size adapts to the syllable envelope. When the three most recent bits agree, the step grows by a fixed increment up to a ceiling. Otherwise it shrinks by a fixed decrement down to a floor. The estimate saturates at three-quarters of full scale, and the step stays frozen while the estimate sits at that limit. An active-low level flag marks when the estimate is at or above half of full scale, for either polarity.

Decisions and received bits are captured on the rising edge of the bit clock. The serial output and the estimate are updated on the falling edge. The clock is the bit clock itself, nominally 16 kHz. Nothing inside the block depends on its rate, so slower clocks work the same way.

Top module: `cvsd_codec`

## Requirements
- R1: Each falling clock edge launches exactly one bit on `bit_out`, namely the decision captured at the rising edge just before it. In encode mode (`mode_dec`=0) that decision is 1 when `sample_in` >= `est_out` (signed) and 0 otherwise.
- R2: `bit_out` never changes at a rising clock edge.
- R3: In decode mode (`mode_dec`=1), `bit_in` is sampled at the rising edge. A change on `bit_in` (or on `sample_in`) after that edge has no effect on the bit or estimate of that period.
- R4: On each falling edge, `est_out` rises by the current step after a 1 bit and falls by it after a 0 bit.
- R5: The step is updated before it is applied. If the new bit equals both of the two previous bits, the step becomes min(step+8, 256). Otherwise it becomes max(step-1, 1).
- R6: If the new estimate would reach +1536 or more, it is held at +1536. If it would reach -1536 or less, it is held at -1536. In both cases `clamped`=1. While `clamped` is 1 the step does not change. `clamped` returns to 0 on the first update that lands strictly inside the limits.
- R7: `agc_n` is 0 exactly when `est_out` >= 1024 or `est_out` <= -1024. Otherwise it is 1.
- R8: With a zero input in encode mode after reset, `est_out` alternates 1,0,1,0,… on successive falling edges, so it toggles at half the bit rate.
- R9: A synchronous active-high `rst` sets `est_out` to 0, the step to 1, the bit history to 0, `clamped` to 0 and `bit_out` to 0.
- R10: A decoder fed the encoder's bit stream from reset produces, bit by bit, the same estimate sequence as the encoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; rising edge samples, falling edge launches |
| rst | input | 1 | Synchronous active-high reset |
| mode_dec | input | 1 | 0 = encode, 1 = decode |
| sample_in | input | 12 | Signed audio input word (encode) |
| bit_in | input | 1 | Serial NRZ bit input (decode) |
| bit_out | output | 1 | Serial NRZ bit output |
| est_out | output | 12 | Signed reconstructed estimate |
| agc_n | output | 1 | Low while estimate magnitude is at or above half scale |
| clamped | output | 1 | High while the estimate is held at its limit |

## Verification
The hardest situation to reach is the frozen-step release. The step must have grown large, the estimate must then be pinned at the limit for many periods, and the input must then reverse, so that the first unclamped move uses the step that was held. The stimulus gets there by driving a full-scale input for sixty periods in each polarity, followed by zero. A sweep of constant levels across the whole input range is also run, along with a triangle wave whose recorded bit stream is replayed in decode mode. During the replay, the inputs are deliberately flipped just after each rising edge.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
   typedef enum logic {
      MODE_ENCODE = 1'b0,
      MODE_DECODE = 1'b1
   } cvsd_mode_e;
endpackage

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
   parameter int STEP_MIN    = 1,
   parameter int STEP_MAX    = 256,
   parameter int STEP_INC    = 8,
   parameter int STEP_DEC    = 1,
   parameter int DECAY_SHIFT = 0,
   localparam int STEP_W     = $clog2(STEP_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_i,
   input  logic              bit_i,
   input  logic              hold_i,
   output logic [STEP_W-1:0] step_o
);
   logic [1:0]        hist_q;
   logic [STEP_W-1:0] step_q;
   logic              run_w;
   int                dec_amt;
   int                grown;
   int                shrunk;

   assign run_w = (bit_i == hist_q[0]) && (bit_i == hist_q[1]);

   generate
      if (DECAY_SHIFT == 0) begin : g_lin_decay
         assign dec_amt = STEP_DEC;
      end else begin : g_prop_decay
         always_comb begin
            dec_amt = int'(step_q >> DECAY_SHIFT);
            if (dec_amt < 1) dec_amt = 1;
         end
      end
   endgenerate

   always_comb begin
      grown  = int'(step_q) + STEP_INC;
      shrunk = int'(step_q) - dec_amt;
      if (grown > STEP_MAX) grown = STEP_MAX;
      if (shrunk < STEP_MIN) shrunk = STEP_MIN;
      if (hold_i)     step_o = step_q;
      else if (run_w) step_o = STEP_W'(grown);
      else            step_o = STEP_W'(shrunk);
   end

   always_ff @(negedge clk) begin
      if (rst) begin
         hist_q <= '0;
         step_q <= STEP_W'(STEP_MIN);
      end else if (upd_i) begin
         hist_q <= {hist_q[0], bit_i};
         step_q <= step_o;
      end
   end

   p_step_range_r5: assert property (@(negedge clk) disable iff (rst)
      (int'(step_q) >= STEP_MIN) && (int'(step_q) <= STEP_MAX))
      else $error("step left its range");

   p_step_frozen_r6: assert property (@(negedge clk) disable iff (rst)
      (upd_i && hold_i) |=> $stable(step_q))
      else $error("step changed while clamped");
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
   parameter int W      = 12,
   parameter int STEP_W = 9
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                upd_i,
   input  logic                bit_i,
   input  logic [STEP_W-1:0]   step_i,
   output logic signed [W-1:0] est_o,
   output logic                clamp_o
);
   localparam logic signed [W:0] LIM = (W+1)'(3 << (W - 3));

   logic signed [W:0] ext_est;
   logic signed [W:0] ext_step;
   logic signed [W:0] cand;
   logic signed [W-1:0] est_q;
   logic                clamp_q;

   assign ext_est  = {est_q[W-1], est_q};
   assign ext_step = $signed({{(W + 1 - STEP_W){1'b0}}, step_i});
   assign cand     = bit_i ? (ext_est + ext_step) : (ext_est - ext_step);

   always_ff @(negedge clk) begin
      if (rst) begin
         est_q   <= '0;
         clamp_q <= 1'b0;
      end else if (upd_i) begin
         if (cand >= LIM) begin
            est_q   <= LIM[W-1:0];
            clamp_q <= 1'b1;
         end else if (cand <= -LIM) begin
            est_q   <= W'(-LIM);
            clamp_q <= 1'b1;
         end else begin
            est_q   <= cand[W-1:0];
            clamp_q <= 1'b0;
         end
      end
   end

   assign est_o   = est_q;
   assign clamp_o = clamp_q;

   p_clamp_bound_r6: assert property (@(negedge clk) disable iff (rst)
      ($signed({est_q[W-1], est_q}) <= LIM) && ($signed({est_q[W-1], est_q}) >= -LIM))
      else $error("estimate beyond clamp limit");
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
   parameter int W           = 12,
   parameter int STEP_MIN    = 1,
   parameter int STEP_MAX    = 256,
   parameter int STEP_INC    = 8,
   parameter int STEP_DEC    = 1,
   parameter int DECAY_SHIFT = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mode_dec,
   input  logic signed [W-1:0] sample_in,
   input  logic                bit_in,
   output logic                bit_out,
   output logic signed [W-1:0] est_out,
   output logic                agc_n,
   output logic                clamped
);
   import cvsd_pkg::*;

   localparam int STEP_W = $clog2(STEP_MAX + 1);
   localparam logic signed [W-1:0] HALF = W'(1 << (W - 2));

   generate
      if (W < 6) begin : g_chk_w
         $error("W must be at least 6");
      end
      if (STEP_MIN < 1 || STEP_MIN > STEP_MAX) begin : g_chk_min
         $error("STEP_MIN must lie in 1..STEP_MAX");
      end
      if (STEP_MAX > (1 << (W - 3))) begin : g_chk_max
         $error("STEP_MAX too large for W");
      end
      if (STEP_INC < 1 || STEP_DEC < 1) begin : g_chk_inc
         $error("step increments must be positive");
      end
   endgenerate

   cvsd_mode_e  mode_w;
   logic        dec_r;
   logic        vld_r;
   logic        bit_q;
   logic [STEP_W-1:0] step_w;

   assign mode_w = cvsd_mode_e'(mode_dec);

   always_ff @(posedge clk) begin
      if (rst) begin
         dec_r <= 1'b0;
         vld_r <= 1'b0;
      end else begin
         dec_r <= (mode_w == MODE_DECODE) ? bit_in : (sample_in >= est_out);
         vld_r <= 1'b1;
      end
   end

   always_ff @(negedge clk) begin
      if (rst)        bit_q <= 1'b0;
      else if (vld_r) bit_q <= dec_r;
   end

   cvsd_step_adapt #(
      .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INC(STEP_INC),
      .STEP_DEC(STEP_DEC), .DECAY_SHIFT(DECAY_SHIFT)
   ) u_step (
      .clk(clk), .rst(rst), .upd_i(vld_r), .bit_i(dec_r),
      .hold_i(clamped), .step_o(step_w)
   );

   cvsd_integrator #(.W(W), .STEP_W(STEP_W)) u_integ (
      .clk(clk), .rst(rst), .upd_i(vld_r), .bit_i(dec_r),
      .step_i(step_w), .est_o(est_out), .clamp_o(clamped)
   );

   assign bit_out = bit_q;
   assign agc_n   = !((est_out >= HALF) || (est_out <= -HALF));

   p_bit_launch_r1: assert property (@(negedge clk) disable iff (rst)
      vld_r |=> (bit_out == $past(dec_r)))
      else $error("launched bit differs from captured decision");

   p_clamp_agc_r7: assert property (@(negedge clk) disable iff (rst)
      clamped |-> !agc_n)
      else $error("clamped estimate without level flag");
endmodule

// File: tb/cvsd_codec_tb.sv
module cvsd_codec_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NREC = 256;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               mode_dec = 1'b0;
   logic signed [11:0] sample_in = '0;
   logic               bit_in = 1'b0;
   logic               bit_out;
   logic signed [11:0] est_out;
   logic               agc_n;
   logic               clamped;

   int checks = 0;
   int errors = 0;

   int m_est, m_step, m_clamp;
   logic m_h0, m_h1;
   logic rec_bit [NREC];
   int   rec_est [NREC];

   always #(CLK_PERIOD/2) clk = ~clk;

   cvsd_codec u_dut (
      .clk(clk), .rst(rst), .mode_dec(mode_dec), .sample_in(sample_in),
      .bit_in(bit_in), .bit_out(bit_out), .est_out(est_out),
      .agc_n(agc_n), .clamped(clamped)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_est = 0; m_step = 1; m_clamp = 0; m_h0 = 1'b0; m_h1 = 1'b0;
   endtask

   task automatic model_bit(input logic d);
      int cand;
      if (m_clamp == 0) begin
         if (d == m_h0 && d == m_h1) m_step = (m_step + 8 > 256) ? 256 : m_step + 8;
         else                        m_step = (m_step - 1 < 1) ? 1 : m_step - 1;
      end
      cand = d ? m_est + m_step : m_est - m_step;
      if (cand >= 1536)       begin m_est = 1536;  m_clamp = 1; end
      else if (cand <= -1536) begin m_est = -1536; m_clamp = 1; end
      else                    begin m_est = cand;  m_clamp = 0; end
      m_h1 = m_h0; m_h0 = d;
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic do_bit(input int s, input logic b, input logic mode,
                         input logic glitch, output logic d);
      logic prev_bo;
      sample_in = 12'(s); bit_in = b; mode_dec = mode;
      prev_bo = bit_out;
      @(posedge clk); #1;
      check("R2 bit_out stable at rising edge", int'(bit_out), int'(prev_bo));
      if (glitch) begin
         bit_in = ~b;
         sample_in = (s >= m_est) ? -12'sd2048 : 12'sd2047;
      end
      @(negedge clk); #1;
      d = mode ? b : (s >= m_est);
      model_bit(d);
      check(glitch ? "R3 bit sampled at rising edge" : "R1 launched bit",
            int'(bit_out), int'(d));
      check("R4 R5 estimate", int'(est_out), m_est);
      check("R6 clamp flag", int'(clamped), m_clamp);
      check("R7 level flag", int'(agc_n),
            (m_est >= 1024 || m_est <= -1024) ? 0 : 1);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      model_reset();
      check("R9 reset estimate", int'(est_out), 0);
      check("R9 reset bit_out", int'(bit_out), 0);
      check("R9 reset clamp", int'(clamped), 0);
      check("R9 reset level flag", int'(agc_n), 1);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic d;
      model_reset();
      @(negedge clk); #1;
      do_reset();

      // R8: idle input toggles between 1 and 0
      for (int i = 0; i < 16; i++) begin
         do_bit(0, 1'b0, 1'b0, 1'b0, d);
         check("R8 idle toggle", int'(est_out), (i % 2 == 0) ? 1 : 0);
      end

      // triangle sweep from reset, recorded for R10
      do_reset();
      for (int i = 0; i < NREC; i++) begin
         int ph, s;
         ph = i % 64;
         s = (ph < 32) ? (ph * 62 - 1000) : (1000 - (ph - 32) * 62);
         do_bit(s, 1'b0, 1'b0, 1'b0, d);
         rec_bit[i] = d;
         rec_est[i] = int'(est_out);
      end

      // R6: pin at both limits with frozen step, then release
      for (int i = 0; i < 60; i++) do_bit(2047, 1'b0, 1'b0, 1'b0, d);
      check("R6 positive limit", int'(est_out), 1536);
      for (int i = 0; i < 60; i++) do_bit(-2048, 1'b0, 1'b0, 1'b0, d);
      check("R6 negative limit", int'(est_out), -1536);
      for (int i = 0; i < 40; i++) do_bit(0, 1'b0, 1'b0, 1'b0, d);

      // constant-level sweep across the whole input range
      do_reset();
      for (int lv = -2048; lv < 2048; lv += 64) begin
         for (int k = 0; k < 8; k++) do_bit(lv, 1'b0, 1'b0, 1'b0, d);
      end

      // R10 and R3: decode the recorded stream with glitches after each sample
      do_reset();
      for (int i = 0; i < NREC; i++) begin
         do_bit(0, rec_bit[i], 1'b1, 1'b1, d);
         check("R10 decoder matches encoder", int'(est_out), rec_est[i]);
      end

      // R9: reset from a clamped state
      for (int i = 0; i < 80; i++) do_bit(0, 1'b1, 1'b1, 1'b0, d);
      check("R6 decode clamp reached", int'(clamped), 1);
      do_reset();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule